// File: doc/BRIEF.md
# Boolean Bit Processor

This unit is the single-bit datapath of a small 8-bit controller. The carry flag is its one-bit accumulator. Each operation names one bit through an 8-bit bit address. The unit splits that address into a byte address and a bit position, then reaches the bit in one of two ways. It can read the byte through a byte-wide memory port, which is enough when only the carry changes. It can also read the byte and write it back with one bit altered. The lower half of the bit-address space maps onto a 16-byte window of internal RAM. The upper half maps onto bit-addressable special function registers, whose byte addresses are multiples of eight.

The carry flag is itself one of the addressable bits, bit 7 of the status byte. An access to that bit address never goes to the memory port and works on the internal carry register directly. The unit writes the status byte back with the live carry in bit 7, so that the byte image and the accumulator stay consistent.

The issuing stage pulses `start_i` with an opcode and a bit address while `busy_o` is low. It then waits for the one-cycle `done_o` pulse.

Top module: `bool_unit`

## Requirements
- R1: After reset, cy_o, busy_o, done_o, mem_rd_o and mem_wr_o are all 0.
- R2: A bit address a below 80h selects byte 20h + a[6:3] and bit position a[2:0]; that byte is the address on the memory port.
- R3: A bit address a of 80h or above, other than D7h, selects byte a with bits [2:0] cleared and bit position a[2:0].
- R4: Opcode 0 sets C to C AND b, 1 sets C to C AND NOT b, 2 sets C to C OR b, and 3 sets C to C OR NOT b, where b is the addressed bit. These opcodes perform one memory read and no write.
- R5: Opcode 4 copies the addressed bit into C, with one memory read and no write.
- R6: Opcode 5 (store C), 6 (set), 7 (clear) and 8 (complement) change only the addressed bit. Each performs a read and then, on the next cycle, a write to the same byte address. The other seven bits of the written byte equal the byte that was read, and C is unchanged.
- R7: Opcode 9 sets C, 10 clears C and 11 complements C. None of them touches the memory port.
- R8: Bit address D7h (status byte, bit 7) is the internal carry register. Every bit opcode applied to it reads or writes C directly, with no memory read or write.
- R9: When the status byte D0h is written back, bit 7 of the write data carries the current C.
- R10: done_o pulses for exactly one cycle. It is high in the 1st cycle after the start edge for register-only operations, the 2nd for read-only operations and the 3rd for read-modify-write operations. busy_o is high from the start edge until the done cycle ends, and start_i is ignored while busy_o is high.
- R11: Opcodes 12 to 15 are no-ops: C is unchanged, the memory port is unused, and done_o follows after one cycle. While idle with start_i low, C holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| op_i | input | 4 | Operation code |
| bit_addr_i | input | 8 | Bit address of the operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cy_o | output | 1 | Carry flag / Boolean accumulator |
| mem_addr_o | output | 8 | Byte address for memory access |
| mem_rd_o | output | 1 | Read strobe; data sampled same cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Byte written back |
| mem_rdata_i | input | 8 | Byte read, valid combinationally with mem_rd_o |

## Verification
The sweep runs every opcode, including the four undefined ones, against every one of the 256 bit addresses. It starts each operation from a carry that varies with the address and opcode, over RAM and register bytes holding differing patterns. A mismatch in the read address separates an error in the low-half decode from one in the high-half decode. A mismatch in the written byte separates a wrong bit position from a clobbered neighbour bit or a stale carry in the status byte. The latency and strobe counts show whether an address of D7h was wrongly routed to memory. Every fifth address keeps start asserted during the operation, which shows whether a request is taken while busy.

// File: rtl/bool_pkg.sv
package bool_pkg;
  typedef enum logic [3:0] {
    OP_ANL   = 4'd0,
    OP_ANL_N = 4'd1,
    OP_ORL   = 4'd2,
    OP_ORL_N = 4'd3,
    OP_MOV_C = 4'd4,
    OP_MOV_B = 4'd5,
    OP_SET_B = 4'd6,
    OP_CLR_B = 4'd7,
    OP_CPL_B = 4'd8,
    OP_SET_C = 4'd9,
    OP_CLR_C = 4'd10,
    OP_CPL_C = 4'd11
  } bool_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } bool_state_e;

  function automatic logic op_uses_bit(logic [3:0] op);
    return op <= 4'd8;
  endfunction

  function automatic logic op_writes_bit(logic [3:0] op);
    return (op >= 4'd5) && (op <= 4'd8);
  endfunction
endpackage

// File: rtl/bool_addr_map.sv
module bool_addr_map #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] CY_ADDR  = 8'hD7
) (
  input  logic [ADDR_W-1:0]          bit_addr_i,
  output logic [ADDR_W-1:0]          byte_o,
  output logic [$clog2(DATA_W)-1:0]  pos_o,
  output logic                       is_cy_o
);
  localparam int POS_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] idx;
  logic [ADDR_W-1:0] hi_byte;

  assign idx     = bit_addr_i >> POS_W;
  assign hi_byte = {bit_addr_i[ADDR_W-1:POS_W], {POS_W{1'b0}}};

  // lower half: RAM window, upper half: register bytes on multiples of DATA_W
  assign byte_o  = bit_addr_i[ADDR_W-1] ? hi_byte : (RAM_BASE + idx);
  assign pos_o   = bit_addr_i[POS_W-1:0];
  assign is_cy_o = (bit_addr_i == CY_ADDR);
endmodule

// File: rtl/bool_alu.sv
module bool_alu
  import bool_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic       cy_i,
  input  logic       bit_i,
  output logic       cy_o,
  output logic       bit_o
);
  always_comb begin
    cy_o  = cy_i;
    bit_o = bit_i;
    case (op_i)
      OP_ANL:   cy_o  = cy_i & bit_i;
      OP_ANL_N: cy_o  = cy_i & ~bit_i;
      OP_ORL:   cy_o  = cy_i | bit_i;
      OP_ORL_N: cy_o  = cy_i | ~bit_i;
      OP_MOV_C: cy_o  = bit_i;
      OP_MOV_B: bit_o = cy_i;
      OP_SET_B: bit_o = 1'b1;
      OP_CLR_B: bit_o = 1'b0;
      OP_CPL_B: bit_o = ~bit_i;
      OP_SET_C: cy_o  = 1'b1;
      OP_CLR_C: cy_o  = 1'b0;
      OP_CPL_C: cy_o  = ~cy_i;
      default:  ;
    endcase
  end
endmodule

// File: rtl/bool_unit.sv
module bool_unit
  import bool_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20,
  parameter logic [ADDR_W-1:0] PSW_ADDR = 8'hD0,
  parameter int                CY_POS   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] bit_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int                POS_W   = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] CY_ADDR = PSW_ADDR + ADDR_W'(CY_POS);

  bool_state_e       state_q;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] byte_q;
  logic [POS_W-1:0]  pos_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wbit_q;
  logic              cy_q;

  logic [ADDR_W-1:0] map_byte;
  logic [POS_W-1:0]  map_pos;
  logic              map_is_cy;
  logic [3:0]        alu_op;
  logic              alu_bit_in;
  logic              alu_cy;
  logic              alu_bit;
  logic              is_psw;
  logic [DATA_W-1:0] wdata;

  bool_addr_map #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RAM_BASE(RAM_BASE),
    .CY_ADDR (CY_ADDR)
  ) u_map (
    .bit_addr_i(bit_addr_i),
    .byte_o    (map_byte),
    .pos_o     (map_pos),
    .is_cy_o   (map_is_cy)
  );

  // idle: operand is C itself (C-only ops or the carry bit address)
  assign alu_op     = (state_q == ST_IDLE) ? op_i : op_q;
  assign alu_bit_in = (state_q == ST_RD) ? mem_rdata_i[pos_q] : cy_q;

  bool_alu u_alu (
    .op_i (alu_op),
    .cy_i (cy_q),
    .bit_i(alu_bit_in),
    .cy_o (alu_cy),
    .bit_o(alu_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      byte_q  <= '0;
      pos_q   <= '0;
      rdata_q <= '0;
      wbit_q  <= 1'b0;
      cy_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q   <= op_i;
            byte_q <= map_byte;
            pos_q  <= map_pos;
            if (op_uses_bit(op_i) && !map_is_cy) begin
              state_q <= ST_RD;
            end else begin
              cy_q    <= op_writes_bit(op_i) ? alu_bit : alu_cy;
              state_q <= ST_DONE;
            end
          end
        end
        ST_RD: begin
          rdata_q <= mem_rdata_i;
          wbit_q  <= alu_bit;
          cy_q    <= alu_cy;
          state_q <= op_writes_bit(op_q) ? ST_WR : ST_DONE;
        end
        ST_WR:   state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign is_psw = (byte_q == PSW_ADDR);

  for (genvar i = 0; i < DATA_W; i++) begin : g_wbit
    if (i == CY_POS) begin : g_cy
      assign wdata[i] = is_psw ? cy_q
                               : ((pos_q == POS_W'(i)) ? wbit_q : rdata_q[i]);
    end else begin : g_plain
      assign wdata[i] = (pos_q == POS_W'(i)) ? wbit_q : rdata_q[i];
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign cy_o        = cy_q;
  assign mem_addr_o  = byte_q;
  assign mem_rd_o    = (state_q == ST_RD);
  assign mem_wr_o    = (state_q == ST_WR);
  assign mem_wdata_o = wdata;
endmodule

// File: rtl/bool_unit_chk.sv
module bool_unit_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] PSW_ADDR = 8'hD0,
  parameter int                CY_POS   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] bit_addr_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              cy_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i
);
  localparam logic [ADDR_W-1:0] CY_ADDR = PSW_ADDR + ADDR_W'(CY_POS);

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_wr_after_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o) && mem_addr_o == $past(mem_addr_o)));

  p_keep_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_addr_o != PSW_ADDR)
      |-> ($countones(mem_wdata_o ^ $past(mem_rdata_i)) <= 1));

  p_psw_cy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_addr_o == PSW_ADDR) |-> (mem_wdata_o[CY_POS] == cy_o));

  p_cy_no_mem_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bit_addr_i == CY_ADDR) |=> (!mem_rd_o && !mem_wr_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(cy_o));
endmodule

bind bool_unit bool_unit_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .PSW_ADDR(PSW_ADDR),
  .CY_POS  (CY_POS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .bit_addr_i (bit_addr_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .cy_o       (cy_o),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rdata_i(mem_rdata_i)
);

// File: tb/bool_unit_tb_top.sv
module bool_unit_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] bit_addr_i = '0;
  logic       busy_o, done_o, cy_o, mem_rd_o, mem_wr_o;
  logic [7:0] mem_addr_o, mem_wdata_o, mem_rdata_i;

  logic       mem_init = 1'b1;
  logic [7:0] mem [256];
  int         rd_cnt = 0;
  int         wr_cnt = 0;
  logic [7:0] last_rd_addr = '0;

  logic [7:0] ref_mem [256];
  logic       ref_cy;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  always #4 clk_i = ~clk_i;

  bool_unit dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .op_i       (op_i),
    .bit_addr_i (bit_addr_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cy_o       (cy_o),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [7:0] pattern(int i);
    return 8'((i * 37 + 91) & 255);
  endfunction

  assign mem_rdata_i = mem[mem_addr_o];

  always @(posedge clk_i) begin
    if (mem_init) begin
      for (int i = 0; i < 256; i++) mem[i] <= pattern(i);
    end else begin
      if (mem_wr_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd_o) begin
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= mem_addr_o;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input bit poke);
    int byte_a, pos, n, exp_n, rd0, wr0;
    bit d7, uses, writes, b, c, nc, nb;
    string tag;
    byte_a = (a < 8'h80) ? (8'h20 + int'(a >> 3)) : int'(a & 8'hF8);
    pos    = int'(a & 8'h07);
    d7     = (a == 8'hD7);
    uses   = (op <= 4'd8);
    writes = (op >= 4'd5) && (op <= 4'd8);
    c      = ref_cy;
    b      = d7 ? c : ref_mem[byte_a][pos];
    nc = c;
    nb = b;
    case (op)
      4'd0: nc = c & b;
      4'd1: nc = c & ~b;
      4'd2: nc = c | b;
      4'd3: nc = c | ~b;
      4'd4: nc = b;
      4'd5: nb = c;
      4'd6: nb = 1'b1;
      4'd7: nb = 1'b0;
      4'd8: nb = ~b;
      4'd9: nc = 1'b1;
      4'd10: nc = 1'b0;
      4'd11: nc = ~c;
      default: ;
    endcase
    if (writes && d7) nc = nb;
    if (!uses || d7) exp_n = 1;
    else if (writes) exp_n = 3;
    else exp_n = 2;
    if (op >= 4'd12) tag = "R11";
    else if (d7 && uses) tag = "R8";
    else if (op <= 4'd3) tag = "R4";
    else if (op == 4'd4) tag = "R5";
    else if (writes) tag = "R6";
    else tag = "R7";

    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk_i);
    start_i = 1'b1;
    op_i = op;
    bit_addr_i = a;
    @(posedge clk_i);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (poke) begin
        start_i = 1'b1;
        op_i = 4'd11;
        bit_addr_i = 8'hD7;
      end else begin
        start_i = 1'b0;
      end
    end while (!done_o && n < 10);
    start_i = 1'b0;

    chk(n == exp_n, "R10", "done latency", n, exp_n);
    chk(cy_o == nc, tag, "carry", int'(cy_o), int'(nc));
    chk(rd_cnt - rd0 == ((exp_n > 1) ? 1 : 0), (exp_n == 1) ? tag : "R2", "read count", rd_cnt - rd0, (exp_n > 1) ? 1 : 0);
    chk(wr_cnt - wr0 == ((exp_n == 3) ? 1 : 0), tag, "write count", wr_cnt - wr0, (exp_n == 3) ? 1 : 0);
    if (exp_n > 1)
      chk(int'(last_rd_addr) == byte_a, (a < 8'h80) ? "R2" : "R3", "byte address", int'(last_rd_addr), byte_a);
    if (writes && !d7) begin
      ref_mem[byte_a][pos] = nb;
      if (byte_a == 8'hD0) ref_mem[byte_a][7] = c;
      chk(mem[byte_a] == ref_mem[byte_a], (byte_a == 8'hD0) ? "R9" : "R6", "written byte",
          int'(mem[byte_a]), int'(ref_mem[byte_a]));
    end
    ref_cy = nc;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = pattern(i);
    ref_cy = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(cy_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1", "reset outputs",
        {cy_o, busy_o, done_o}, 0);
    chk(mem_rd_o == 1'b0 && mem_wr_o == 1'b0, "R1", "reset strobes", {mem_rd_o, mem_wr_o}, 0);
    rst_ni = 1'b1;
    mem_init = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(cy_o == 1'b0, "R11", "idle hold", int'(cy_o), 0);

    for (int a = 0; a < 256; a++) begin
      for (int op = 0; op < 16; op++) begin
        bit want;
        want = 1'((a ^ (op >> 1) ^ (a >> 3)) & 1);
        run_op(want ? 4'd9 : 4'd10, 8'(a), 1'b0);
        run_op(4'(op), 8'(a), (a % 5) == 0);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule